// File: doc/BRIEF.md
# Floating-Point Immediate Insert Unit

This execution unit serves two floating-point immediate operations that never access memory. In the load form, a 16-bit immediate forms the upper half of a single-precision value. The lower sixteen fraction bits are zero. The unit widens that value to double format and returns it as the new contents of a 64-bit FP register.

In the insert form, the unit takes the current 64-bit register value and narrows it to single format. It then replaces the lower sixteen bits of that single with the immediate, widens the result back to double, and returns it. In this form the same register is both source and destination.

A load followed by an insert therefore builds any 32-bit single-precision constant in a register, with no memory access. Neither operation reports any floating-point status or exception. Widening always normalises single denormals, so every single value, denormals included, arrives in the register as the matching double.

The result is registered. A write-valid strobe marks it one clock after an issue strobe.

Top module: `fp_imm_insert`

## Requirements
- R1: While reset is asserted, and after it is released until the first issue, `wr_vld_o` is 0 and `res_o` is all zeros.
- R2: `wr_vld_o` is 1 in exactly the cycle after a cycle with `issue_i` = 1. `res_o` holds its value when no operation was issued in the previous cycle.
- R3: With `op_i` = 0 (load form), the single value is {imm, 16 zero bits}: imm[15] is the sign, imm[14:7] the full exponent, imm[6:0] the top fraction bits. The result is that single widened to double, and its low 29 bits are always 0.
- R4: A zero single (exponent and fraction both zero) widens to a double with the same sign and all other bits 0. Load-form immediate 0x0000 gives +0.0 (all 64 bits zero) whatever `rd_val_i` holds.
- R5: A single exponent of all ones (infinity or NaN) widens to double exponent 0x7FF, with the 23-bit fraction placed in result bits [51:29], so that payloads are kept.
- R6: A normal single widens with exponent (single exponent + 896) and fraction in bits [51:29].
- R7: A denormal single (exponent 0, fraction nonzero) is normalised. With z leading zeros in the 23-bit fraction, the double exponent is 896 − z and the fraction bits after the leading one are left-aligned at bit 51.
- R8: Insert form, narrowing: when the double exponent E (bits [62:52]) is above 896, or below 874, or all zeros, or all ones, the single is {bit 63, bit 62, bits [58:52], bits [51:29]}. Lower bits are discarded without rounding.
- R9: Insert form, narrowing: when 874 ≤ E ≤ 896, the single is a denormal. Its fraction is {1, bits [51:29]} shifted right by (897 − E), with no rounding, and its sign is bit 63.
- R10: Insert form: the low 16 bits of the narrowed single are replaced by the immediate and the result is widened by R4–R7. In the load form `rd_val_i` has no effect on the result.
- R11: A load of the upper half of any 32-bit single pattern P, followed by an insert of P's lower half on that result, yields P widened to double.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Starts an operation this cycle |
| op_i | input | 1 | 0 = load form, 1 = insert form |
| imm_i | input | 16 | Immediate field |
| rd_val_i | input | 64 | Current contents of the target FP register |
| res_o | output | 64 | Value to write into the target register |
| wr_vld_o | output | 1 | Result valid, one cycle after issue |

## Verification
The hardest case to reach from the ports is the insert form narrowing a register value in the single-denormal band, or one holding fraction bits below single precision. A widened single never has those low bits, so chained operations alone do not reach this case. The bench drives hand-built doubles on `rd_val_i` at the band edges: exponents 874 and 896, and an all-ones fraction that would carry if it were rounded.

The load form is swept over all 65536 immediates, with random data on the register input. A chain of load-then-insert operations feeds the captured result back as the register value. That chain rebuilds random and boundary single patterns, and the bench compares each result against doubles it computes with real arithmetic.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
   typedef enum logic {
      OP_LOAD   = 1'b0,
      OP_INSERT = 1'b1
   } fpimm_op_e;
endpackage

// File: rtl/fpimm_lead_zero.sv
module fpimm_lead_zero #(
   parameter int W  = 23,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] lz_o
);
   // Scan upward so the highest set bit is the last one to assign.
   always_comb begin
      lz_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) lz_o = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen #(
   parameter int SE = 8,
   parameter int SF = 23,
   parameter int DE = 11,
   parameter int DF = 52,
   localparam int SW = 1 + SE + SF,
   localparam int DW = 1 + DE + DF
) (
   input  logic [SW-1:0] sp_i,
   output logic [DW-1:0] dp_o
);
   localparam int BIAS_DIFF = (1 << (DE - 1)) - (1 << (SE - 1));
   localparam int PAD       = DF - SF;
   localparam int CW        = $clog2(SF + 1);

   logic          sgn;
   logic [SE-1:0] ex;
   logic [SF-1:0] fr;
   logic [CW-1:0] lz;
   logic [CW-1:0] shamt;
   logic [SF-1:0] fr_norm;

   assign sgn = sp_i[SW-1];
   assign ex  = sp_i[SW-2 -: SE];
   assign fr  = sp_i[SF-1:0];

   fpimm_lead_zero #(.W(SF)) u_lz (
      .vec_i (fr),
      .lz_o  (lz)
   );

   assign shamt   = lz + CW'(1);
   assign fr_norm = fr << shamt;

   always_comb begin
      if (ex == '0 && fr == '0) begin
         dp_o = {sgn, {(DW-1){1'b0}}};
      end else if (ex == '0) begin
         dp_o = {sgn, DE'(BIAS_DIFF) - DE'(lz), fr_norm, {PAD{1'b0}}};
      end else if (ex == '1) begin
         dp_o = {sgn, {DE{1'b1}}, fr, {PAD{1'b0}}};
      end else begin
         dp_o = {sgn, DE'(ex) + DE'(BIAS_DIFF), fr, {PAD{1'b0}}};
      end
   end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow #(
   parameter int SE = 8,
   parameter int SF = 23,
   parameter int DE = 11,
   parameter int DF = 52,
   localparam int SW = 1 + SE + SF,
   localparam int DW = 1 + DE + DF
) (
   input  logic [DW-1:0] dp_i,
   output logic [SW-1:0] sp_o
);
   localparam int BIAS_DIFF = (1 << (DE - 1)) - (1 << (SE - 1));
   localparam int DENORM_LO = BIAS_DIFF - SF + 1;
   localparam int PAD       = DF - SF;

   logic          sgn;
   logic [DE-1:0] ex;
   logic [SF-1:0] fr;
   logic [SF:0]   sig;
   logic [DE-1:0] rsh;
   logic [SF:0]   sig_sh;
   logic          in_band;
   logic [PAD-1:0] unused_low;

   assign sgn        = dp_i[DW-1];
   assign ex         = dp_i[DW-2 -: DE];
   assign fr         = dp_i[DF-1 -: SF];
   assign unused_low = dp_i[PAD-1:0];
   assign sig        = {1'b1, fr};
   assign rsh        = DE'(BIAS_DIFF + 1) - ex;
   assign sig_sh     = sig >> rsh;
   assign in_band    = (ex >= DE'(DENORM_LO)) && (ex <= DE'(BIAS_DIFF));

   always_comb begin
      if (in_band) begin
         sp_o = {sgn, {SE{1'b0}}, sig_sh[SF-1:0]};
      end else begin
         sp_o = {sgn, ex[DE-1], ex[SE-2:0], fr};
      end
   end
endmodule

// File: rtl/fp_imm_insert.sv
module fp_imm_insert #(
   parameter int IMM_W    = 16,
   parameter int SP_EXP_W = 8,
   parameter int SP_FRC_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_FRC_W = 52
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 issue_i,
   input  logic                                 op_i,
   input  logic [IMM_W-1:0]                     imm_i,
   input  logic [DP_EXP_W+DP_FRC_W:0]           rd_val_i,
   output logic [DP_EXP_W+DP_FRC_W:0]           res_o,
   output logic                                 wr_vld_o
);
   import fpimm_pkg::*;

   localparam int SP_W = 1 + SP_EXP_W + SP_FRC_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_FRC_W;
   localparam int LO_W = SP_W - IMM_W;

   if (DP_FRC_W < SP_FRC_W) begin : g_bad_frac
      $error("double fraction narrower than single fraction");
   end
   if (DP_EXP_W <= SP_EXP_W) begin : g_bad_exp
      $error("double exponent must be wider than single exponent");
   end
   if (IMM_W < SP_EXP_W + 2 || IMM_W >= SP_W) begin : g_bad_imm
      $error("immediate must cover sign, exponent and part of fraction");
   end

   fpimm_op_e       op_e;
   logic [SP_W-1:0] sp_narrow;
   logic [SP_W-1:0] sp_sel;
   logic [DP_W-1:0] dp_wide;
   logic [IMM_W-1:0] unused_lo;

   assign op_e      = fpimm_op_e'(op_i);
   assign unused_lo = sp_narrow[IMM_W-1:0];

   fpimm_narrow #(
      .SE (SP_EXP_W), .SF (SP_FRC_W), .DE (DP_EXP_W), .DF (DP_FRC_W)
   ) u_narrow (
      .dp_i (rd_val_i),
      .sp_o (sp_narrow)
   );

   always_comb begin
      if (op_e == OP_INSERT) sp_sel = {sp_narrow[SP_W-1:IMM_W], imm_i};
      else                   sp_sel = {imm_i, {LO_W{1'b0}}};
   end

   // One widener shared by both forms.
   fpimm_widen #(
      .SE (SP_EXP_W), .SF (SP_FRC_W), .DE (DP_EXP_W), .DF (DP_FRC_W)
   ) u_widen (
      .sp_i (sp_sel),
      .dp_o (dp_wide)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o    <= '0;
         wr_vld_o <= 1'b0;
      end else begin
         wr_vld_o <= issue_i;
         if (issue_i) res_o <= dp_wide;
      end
   end
endmodule

// File: rtl/fp_imm_insert_chk.sv
module fp_imm_insert_chk #(
   parameter int IMM_W = 16,
   parameter int SE    = 8,
   parameter int SF    = 23,
   parameter int DE    = 11,
   parameter int DF    = 52,
   localparam int DW   = 1 + DE + DF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue_i,
   input logic             op_i,
   input logic [IMM_W-1:0] imm_i,
   input logic [DW-1:0]    res_o,
   input logic             wr_vld_o
);
   localparam int BIAS_DIFF = (1 << (DE - 1)) - (1 << (SE - 1));
   localparam int PAD       = DF - SF;

   logic [SE-1:0] imm_ex;
   assign imm_ex = imm_i[IMM_W-2 -: SE];

   assert_vld_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> wr_vld_o);
   assert_no_spurious_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> !wr_vld_o);
   assert_res_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(res_o));
   assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> res_o[PAD-1:0] == '0);
   assert_zero_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !op_i && imm_i == '0) |=> res_o == '0);
   assert_special_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !op_i && imm_ex == '1) |=> res_o[DW-2 -: DE] == '1);
   assert_normal_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !op_i && imm_ex != '0 && imm_ex != '1) |=>
      res_o[DW-2 -: DE] == DE'($past(imm_ex)) + DE'(BIAS_DIFF));
   assert_load_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !op_i) |=> res_o[DW-1] == $past(imm_i[IMM_W-1]));
endmodule

bind fp_imm_insert fp_imm_insert_chk #(
   .IMM_W (IMM_W), .SE (SP_EXP_W), .SF (SP_FRC_W), .DE (DP_EXP_W), .DF (DP_FRC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .issue_i  (issue_i),
   .op_i     (op_i),
   .imm_i    (imm_i),
   .res_o    (res_o),
   .wr_vld_o (wr_vld_o)
);

// File: tb/fp_imm_insert_test.sv
module fp_imm_insert_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic        op_i = 1'b0;
   logic [15:0] imm_i = '0;
   logic [63:0] rd_val_i = '0;
   logic [63:0] res_o;
   logic        wr_vld_o;

   int          n_tests = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

   always #5 clk = ~clk;

   fp_imm_insert uut (
      .clk (clk), .rst_n (rst_n), .issue_i (issue_i), .op_i (op_i),
      .imm_i (imm_i), .rd_val_i (rd_val_i), .res_o (res_o), .wr_vld_o (wr_vld_o)
   );

   function automatic logic [63:0] next_rand();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed;
   endfunction

   // Reference: single bit pattern to double by real arithmetic.
   function automatic logic [63:0] ref_widen(input logic [31:0] p);
      logic       s = p[31];
      int         e = int'(p[30:23]);
      int         f = int'(p[22:0]);
      int         mant;
      int         k;
      real        r;
      if (e == 255) return {s, 11'h7FF, p[22:0], 29'h0};
      mant = (e == 0) ? f : f + (1 << 23);
      if (mant == 0) return {s, 63'h0};
      k = ((e == 0) ? 1 : e) - 150;
      r = real'(mant);
      if (k > 0) repeat (k) r = r * 2.0;
      else repeat (-k) r = r * 0.5;
      if (s) r = -r;
      return $realtobits(r);
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: imm=%h rd=%h got %h expected %h", req, imm_i, rd_val_i, got, exp);
      end
   endtask

   // Issue at a falling edge, sample at the next falling edge.
   task automatic run_op(input string req, input logic op, input logic [15:0] imm,
                         input logic [63:0] rd, input logic [63:0] exp);
      issue_i  = 1'b1;
      op_i     = op;
      imm_i    = imm;
      rd_val_i = rd;
      @(negedge clk);
      check({req, " valid"}, {63'h0, wr_vld_o}, 64'h1);
      check(req, res_o, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] prev;
      repeat (3) @(negedge clk);
      check("R1 reset vld", {63'h0, wr_vld_o}, 64'h0);
      check("R1 reset res", res_o, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle vld", {63'h0, wr_vld_o}, 64'h0);
      check("R1 idle res", res_o, 64'h0);

      // Named load-form corners
      run_op("R4 zero imm ignores reg", 1'b0, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      run_op("R4 negative zero", 1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000);
      run_op("R5 +inf", 1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000);
      run_op("R5 -inf", 1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000);
      run_op("R5 quiet NaN", 1'b0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000);
      run_op("R6 one", 1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000);
      run_op("R7 smallest denormal", 1'b0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000);
      run_op("R7 largest denormal", 1'b0, 16'h007F, 64'h0, 64'h380F_C000_0000_0000);

      // R2: result holds and strobe drops without issue
      prev = res_o;
      issue_i = 1'b0;
      imm_i = 16'h1234;
      @(negedge clk);
      check("R2 no issue vld", {63'h0, wr_vld_o}, 64'h0);
      check("R2 no issue hold", res_o, prev);

      // Exhaustive load-form sweep with random register data (R3, R10)
      for (int i = 0; i < 65536; i++) begin
         logic [15:0] im = 16'(i);
         string req;
         if (im[14:7] == 8'hFF)             req = "R5 sweep";
         else if (im[14:0] == 15'h0)        req = "R4 sweep";
         else if (im[14:7] == 8'h00)        req = "R7 sweep";
         else                               req = "R6 sweep R3 R10";
         run_op(req, 1'b0, im, next_rand(), ref_widen({im, 16'h0}));
      end

      // Insert form with hand-built register values
      run_op("R8 truncate low bits", 1'b1, 16'h1234, 64'h3FF0_0000_0000_0001,
             ref_widen(32'h3F80_1234));
      run_op("R8 NaN narrow", 1'b1, 16'h0001, 64'h7FF8_0000_0000_0000,
             ref_widen(32'h7FC0_0001));
      run_op("R8 -inf narrow", 1'b1, 16'h0000, 64'hFFF0_0000_0000_0000,
             64'hFFF0_0000_0000_0000);
      run_op("R8 -zero narrow", 1'b1, 16'h0000, 64'h8000_0000_0000_0000,
             64'h8000_0000_0000_0000);
      run_op("R8 normal R10", 1'b1, 16'h8000, 64'hC000_0000_0000_0000,
             ref_widen(32'hC000_8000));
      run_op("R9 band top", 1'b1, 16'h0000, 64'h3800_0000_0000_0000,
             ref_widen(32'h0040_0000));
      run_op("R9 no rounding", 1'b1, 16'h0000, 64'h380F_FFFF_FFFF_FFFF,
             ref_widen(32'h007F_0000));
      run_op("R9 mid band", 1'b1, 16'hABCD, 64'h3730_0000_0000_0000,
             ref_widen(32'h0000_ABCD));
      run_op("R9 band bottom", 1'b1, 16'hFFFF, 64'h36A0_0000_0000_0000,
             ref_widen(32'h0000_FFFF));

      // R11: load then insert rebuilds singles
      for (int i = 0; i < 2005; i++) begin
         logic [31:0] p;
         logic [63:0] mid;
         case (i)
            0: p = 32'h0000_0001;
            1: p = 32'h007F_FFFF;
            2: p = 32'h7F7F_FFFF;
            3: p = 32'h0080_0000;
            4: p = 32'h8000_0001;
            default: p = next_rand()[47:16];
         endcase
         run_op("R11 load half", 1'b0, p[31:16], next_rand(), ref_widen({p[31:16], 16'h0}));
         mid = res_o;
         run_op("R11 insert half", 1'b1, p[15:0], mid, ref_widen(p));
      end

      issue_i = 1'b0;
      @(negedge clk);
      check("R2 final idle", {63'h0, wr_vld_o}, 64'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule